// File: doc/BRIEF.md
# Interleaved Memory Line-Fill Controller

This block serves one cache-line fill at a time out of a main-memory model split into four word-interleaved banks. A word address goes to bank `address mod 4`, so the four words of an aligned line sit in four different banks. A single start strobe with a line address starts one address phase that reaches every bank at the same moment. The four banks then perform their fixed-latency lookups in parallel. Afterwards the controller sends the four words one by one over one 32-bit return bus, with a fixed cost per word. With the default costs (4 cycles of address, 24 of bank access, 4 per returned word) the fill takes 44 cycles. The same line from one non-interleaved bank would take 128.

The sequencer passes through five states. `ST_IDLE` waits for a start. `ST_ADDR` spends the address cycles, and on its last cycle it strobes all banks together. `ST_ACCESS` spends the bank access cycles. `ST_XFER` runs one transfer slot per word, in bank order. `ST_DONE` lasts one cycle and raises the done flag. The transitions are: idle to address on an accepted start; address to access when the address phase ends; access to transfer when the access phase ends; transfer to done when the slot of the last word ends; and done back to idle unconditionally. A synchronous reset returns the sequencer to `ST_IDLE` from any state. Each bank holds a small array that reset fills with a computed pattern. The block also reports the length of the last completed miss in cycles.

Top module: `lf_fill_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `fill_valid` and `done` are 0, `fill_data` is 0 and `miss_cycles` is 0.
- R2: `busy` rises in the cycle after an accepted start and stays high up to and including the single cycle in which `done` is high. It is low in the cycle after `done`.
- R3: Number the clock edge that accepts a start as edge 0. Word k (k = 0..3) is presented in the cycle after edge 31+4k. `done` is high in the cycle after edge 44.
- R4: Words come back in bank order 0,1,2,3. Each has exactly one cycle of `fill_valid`, and `fill_word` carries the index k in that cycle.
- R5: Word k of a line whose row is r = req_addr[5:2] carries the value of global word g = 4r + k, which is (g × 0x9E3779B9) XOR 0x5A5AC3C3 modulo 2^32. `fill_data` is 0 whenever `fill_valid` is low.
- R6: The two lowest bits of `req_addr` do not affect which line is returned.
- R7: A start in any cycle while `busy` is high, including the `done` cycle, is ignored. The running fill keeps its address and timing, and no new fill begins after `done`.
- R8: From the cycle after `done` onward, `miss_cycles` holds 44, the count of cycles spent in the address, access and transfer phases. It does not change at any other time.
- R9: A start presented in the first idle cycle after `done` is accepted, so fills can run back to back.
- R10: A reset asserted in the middle of a fill aborts it: after the reset edge `busy`, `done` and `fill_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Fill request strobe, sampled while idle |
| req_addr | input | 6 | Word address of the requested line; bits [1:0] ignored |
| busy | output | 1 | High from the cycle after acceptance to the done cycle |
| fill_valid | output | 1 | One-cycle pulse marking a returned word |
| fill_word | output | 2 | Index of the word within the line |
| fill_data | output | 32 | Returned word, zero when not valid |
| done | output | 1 | One-cycle pulse after the last word |
| miss_cycles | output | 16 | Cycle count of the last completed fill |

## Verification
The bench times each fill against the edge that accepted it, and it looks for each word pulse at its exact cycle. A phase counter that is off by one therefore shows up as a word one cycle early or late, or as a `done` that is misplaced. Starts are injected in the middle of a fill and again in the done cycle. A design that re-arms on these would either stretch `busy` or return data from the wrong line. The bench also issues pairs of addresses that differ only in their low two bits. It runs fills back to back from the first idle cycle, where a design that drops that start would miss the fill. It resets in the middle of a fill, where a design that keeps state across the reset would keep busy high. Random line addresses cover every bank row and check that words land in bank order with the pattern value.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACCESS,
        ST_XFER,
        ST_DONE
    } fill_state_t;

    localparam logic [31:0] FILL_MULT = 32'h9E37_79B9;
    localparam logic [31:0] FILL_MASK = 32'h5A5A_C3C3;

    // Reset-time content of global word g in the interleaved memory model.
    function automatic logic [31:0] fill_pattern(input logic [31:0] g);
        return (g * FILL_MULT) ^ FILL_MASK;
    endfunction

endpackage

// File: rtl/lf_bank.sv
module lf_bank #(
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 4,
    parameter int BANK_IDX  = 0,
    parameter int NUM_BANKS = 4,
    parameter int ACC_CYC   = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_stb,
    input  logic [ROW_W-1:0]  row,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy
);
    localparam int DEPTH = 1 << ROW_W;
    localparam int CW    = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [ROW_W-1:0]  row_q;
    logic [CW-1:0]     acc_cnt;
    logic              in_access;

    // Storage: loaded with the global-address pattern at reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= DATA_W'(lf_pkg::fill_pattern(32'(i * NUM_BANKS + BANK_IDX)));
            end
        end
    end

    // Fixed-latency access started by the shared address strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_q     <= '0;
            acc_cnt   <= '0;
            in_access <= 1'b0;
            rdy       <= 1'b0;
            rdata     <= '0;
        end else if (addr_stb) begin
            row_q     <= row;
            acc_cnt   <= '0;
            in_access <= 1'b1;
            rdy       <= 1'b0;
        end else if (in_access) begin
            if (acc_cnt == CW'(ACC_CYC - 1)) begin
                rdata     <= cells[row_q];
                rdy       <= 1'b1;
                in_access <= 1'b0;
            end else begin
                acc_cnt <= acc_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lf_seq.sv
module lf_seq #(
    parameter int ADDR_CYC  = 4,
    parameter int ACC_CYC   = 24,
    parameter int XFER_CYC  = 4,
    parameter int NUM_WORDS = 4,
    parameter int LAT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    output lf_pkg::fill_state_t          state,
    output logic                         accept,
    output logic                         busy,
    output logic                         done,
    output logic                         addr_stb,
    output logic                         slot_end,
    output logic [$clog2(NUM_WORDS)-1:0] word_idx,
    output logic [LAT_W-1:0]             last_lat
);
    import lf_pkg::*;

    localparam int PH_A   = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
    localparam int PH_MAX = (PH_A > XFER_CYC) ? PH_A : XFER_CYC;
    localparam int PW     = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam int WW     = $clog2(NUM_WORDS);

    fill_state_t      nxt;
    logic [PW-1:0]    phase;
    logic             phase_last;
    logic             last_word;
    logic [LAT_W-1:0] run_cnt;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        phase_last = 1'b0;
        unique case (state)
            ST_ADDR:   phase_last = (phase == PW'(ADDR_CYC - 1));
            ST_ACCESS: phase_last = (phase == PW'(ACC_CYC - 1));
            ST_XFER:   phase_last = (phase == PW'(XFER_CYC - 1));
            default:   phase_last = 1'b0;
        endcase
    end

    assign last_word = (word_idx == WW'(NUM_WORDS - 1));

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start)                   nxt = ST_ADDR;
            ST_ADDR:   if (phase_last)              nxt = ST_ACCESS;
            ST_ACCESS: if (phase_last)              nxt = ST_XFER;
            ST_XFER:   if (phase_last && last_word) nxt = ST_DONE;
            ST_DONE:                                nxt = ST_IDLE;
            default:                                nxt = ST_IDLE;
        endcase
    end

    // Phase, word and latency counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            word_idx <= '0;
            run_cnt  <= '0;
            last_lat <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    phase    <= '0;
                    word_idx <= '0;
                    run_cnt  <= '0;
                end
                ST_ADDR, ST_ACCESS, ST_XFER: begin
                    run_cnt <= run_cnt + 1'b1;
                    if (phase_last) begin
                        phase <= '0;
                        if (state == ST_XFER) word_idx <= word_idx + 1'b1;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_DONE: begin
                    last_lat <= run_cnt;
                    phase    <= '0;
                end
                default: phase <= '0;
            endcase
        end
    end

    // Outputs decoded from state.
    always_comb begin
        accept   = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        addr_stb = 1'b0;
        slot_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_ADDR:   addr_stb = phase_last;
            ST_ACCESS: ;
            ST_XFER:   slot_end = phase_last;
            ST_DONE:   done     = 1'b1;
            default:   busy     = 1'b0;
        endcase
    end

endmodule

// File: rtl/lf_retmux.sv
module lf_retmux #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS*DATA_W-1:0]  bank_data,
    input  logic [NUM_BANKS-1:0]         bank_rdy,
    input  logic [$clog2(NUM_BANKS)-1:0] sel,
    input  logic                         slot_end,
    output logic                         valid,
    output logic [DATA_W-1:0]            data
);
    assign valid = slot_end & bank_rdy[sel];

    always_comb begin
        data = '0;
        if (valid) data = bank_data[sel*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/lf_fill_ctrl.sv
module lf_fill_ctrl #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 6,
    parameter int ADDR_CYC  = 4,
    parameter int ACC_CYC   = 24,
    parameter int XFER_CYC  = 4,
    parameter int LAT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         busy,
    output logic                         fill_valid,
    output logic [$clog2(NUM_BANKS)-1:0] fill_word,
    output logic [DATA_W-1:0]            fill_data,
    output logic                         done,
    output logic [LAT_W-1:0]             miss_cycles
);
    localparam int WORD_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - WORD_W;

    lf_pkg::fill_state_t        seq_state;
    logic                       accept;
    logic                       addr_stb;
    logic                       slot_end;
    logic [ROW_W-1:0]           row_q;
    logic [NUM_BANKS-1:0]       banks_rdy;
    logic [NUM_BANKS*DATA_W-1:0] bank_data;

    // Line row captured on acceptance; word-select bits are dropped.
    always_ff @(posedge clk) begin
        if (rst)         row_q <= '0;
        else if (accept) row_q <= req_addr[ADDR_W-1:WORD_W];
    end

    lf_seq #(
        .ADDR_CYC (ADDR_CYC),
        .ACC_CYC  (ACC_CYC),
        .XFER_CYC (XFER_CYC),
        .NUM_WORDS(NUM_BANKS),
        .LAT_W    (LAT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .state   (seq_state),
        .accept  (accept),
        .busy    (busy),
        .done    (done),
        .addr_stb(addr_stb),
        .slot_end(slot_end),
        .word_idx(fill_word),
        .last_lat(miss_cycles)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        lf_bank #(
            .DATA_W   (DATA_W),
            .ROW_W    (ROW_W),
            .BANK_IDX (b),
            .NUM_BANKS(NUM_BANKS),
            .ACC_CYC  (ACC_CYC)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .addr_stb(addr_stb),
            .row     (row_q),
            .rdata   (bank_data[b*DATA_W +: DATA_W]),
            .rdy     (banks_rdy[b])
        );
    end

    lf_retmux #(
        .DATA_W   (DATA_W),
        .NUM_BANKS(NUM_BANKS)
    ) u_mux (
        .bank_data(bank_data),
        .bank_rdy (banks_rdy),
        .sel      (fill_word),
        .slot_end (slot_end),
        .valid    (fill_valid),
        .data     (fill_data)
    );

endmodule

// File: rtl/lf_fill_chk.sv
module lf_fill_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ADDR_CYC  = 4,
    parameter int ACC_CYC   = 24,
    parameter int XFER_CYC  = 4,
    parameter int LAT_W     = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         busy,
    input logic                         fill_valid,
    input logic [$clog2(NUM_BANKS)-1:0] fill_word,
    input logic [DATA_W-1:0]            fill_data,
    input logic                         done,
    input logic [LAT_W-1:0]             miss_cycles,
    input lf_pkg::fill_state_t          seq_state,
    input logic [NUM_BANKS-1:0]         banks_rdy
);
    localparam int TOTAL = ADDR_CYC + ACC_CYC + NUM_BANKS * XFER_CYC;
    localparam int WW    = $clog2(NUM_BANKS);

    logic [LAT_W-1:0] run_cnt;
    logic [WW:0]      word_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            word_seen <= '0;
        end else if (start && !busy) begin
            run_cnt   <= '0;
            word_seen <= '0;
        end else begin
            if (busy && !done) run_cnt <= run_cnt + 1'b1;
            if (fill_valid)    word_seen <= word_seen + 1'b1;
        end
    end

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!busy && !done && !fill_valid));

    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

    assert_done_release_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

    assert_word_order_R4: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (32'(fill_word) == 32'(word_seen)));

    assert_all_words_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(word_seen) == NUM_BANKS));

    assert_fill_length_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(run_cnt) == TOTAL));

    assert_banks_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_state == lf_pkg::ST_XFER) |-> (&banks_rdy));

    assert_data_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !fill_valid |-> (fill_data == '0));

    assert_lat_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(miss_cycles));

endmodule

bind lf_fill_ctrl lf_fill_chk #(
    .DATA_W   (DATA_W),
    .NUM_BANKS(NUM_BANKS),
    .ADDR_CYC (ADDR_CYC),
    .ACC_CYC  (ACC_CYC),
    .XFER_CYC (XFER_CYC),
    .LAT_W    (LAT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .fill_valid (fill_valid),
    .fill_word  (fill_word),
    .fill_data  (fill_data),
    .done       (done),
    .miss_cycles(miss_cycles),
    .seq_state  (seq_state),
    .banks_rdy  (banks_rdy)
);

// File: tb/sim_lf_fill_ctrl.sv
module sim_lf_fill_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FILL_LEN   = 44;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  req_addr = '0;
    logic        busy;
    logic        fill_valid;
    logic [1:0]  fill_word;
    logic [31:0] fill_data;
    logic        done;
    logic [15:0] miss_cycles;

    int total = 0;
    int bad   = 0;
    logic [15:0] lat_prev = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lf_fill_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .req_addr   (req_addr),
        .busy       (busy),
        .fill_valid (fill_valid),
        .fill_word  (fill_word),
        .fill_data  (fill_data),
        .done       (done),
        .miss_cycles(miss_cycles)
    );

    function automatic logic [31:0] expect_word(input logic [3:0] row, input int k);
        logic [31:0] g;
        g = 32'(row) * 32'd4 + 32'(k);
        return (g * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge while idle; returns at the negedge after edge 45.
    task automatic do_fill(input logic [5:0] a, input bit poke);
        logic [3:0] row;
        int k;
        row = a[5:2];
        start = 1'b1;
        req_addr = a;
        @(posedge clk);  // edge 0 accepts the start (R9 when back to back)
        for (int n = 0; n <= 45; n++) begin
            @(negedge clk);
            start = 1'b0;
            req_addr = 6'($urandom);
            chk("R2 busy", 32'(busy), 32'(n <= FILL_LEN));
            chk("R3 done", 32'(done), 32'(n == FILL_LEN));
            if (n >= 31 && n <= 43 && ((n - 31) % 4 == 0)) begin
                k = (n - 31) / 4;
                chk("R3 valid", 32'(fill_valid), 32'd1);
                chk("R4 word index", 32'(fill_word), 32'(k));
                chk("R5 data", fill_data, expect_word(row, k));
            end else begin
                chk("R4 valid pulse", 32'(fill_valid), 32'd0);
                chk("R5 idle data", fill_data, 32'd0);
            end
            if (n <= 44) chk("R8 stable", 32'(miss_cycles), 32'(lat_prev));
            else         chk("R8 latency", 32'(miss_cycles), 32'(FILL_LEN));
            if (poke && (n == 9 || n == 20 || n == 44)) begin
                start = 1'b1;  // R7: must be ignored
            end
        end
        start = 1'b0;
        lat_prev = 16'(FILL_LEN);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 valid", 32'(fill_valid), 32'd0);
        chk("R1 data", fill_data, 32'd0);
        chk("R1 latency", 32'(miss_cycles), 32'd0);

        // Directed: first and last row, low bits ignored (R6).
        do_fill(6'd0, 1'b0);
        do_fill(6'd63, 1'b0);          // back to back (R9)
        do_fill(6'd21, 1'b0);          // row 5, low bits 01 (R6)
        do_fill(6'd22, 1'b0);          // row 5, low bits 10 (R6)
        repeat (3) @(negedge clk);
        do_fill(6'd40, 1'b1);          // starts while busy (R7)

        // Reset in the middle of a fill (R10).
        start = 1'b1;
        req_addr = 6'd12;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (17) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 valid", 32'(fill_valid), 32'd0);
        chk("R1 latency after reset", 32'(miss_cycles), 32'd0);
        lat_prev = '0;
        repeat (40) @(negedge clk);
        chk("R10 stays idle", 32'(busy), 32'd0);

        // Random fills with occasional gaps and injected starts.
        for (int i = 0; i < 10; i++) begin
            if ($urandom_range(1, 0) == 1) repeat ($urandom_range(4, 1)) @(negedge clk);
            do_fill(6'($urandom), bit'($urandom_range(1, 0)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule